// File: doc/BRIEF.md
# Dual-Channel Compare-Match Interval Timer

This peripheral holds two independent up-counting timer channels behind a small synchronous register bus. Each channel divides the input clock by a selectable ratio. Every divided tick advances a 16-bit counter. When the counter has reached the channel's compare value, the next tick returns it to zero and latches a match flag. The flag, qualified by a per-channel enable bit, drives that channel's interrupt line. Software typically stops a channel, presets its counter and compare value, selects the divide ratio and enables the interrupt, then sets the channel's run bit. In the interrupt handler it clears the flag with a read-modify-write that has zero in the flag position.

The run bits of all channels live in one shared register at offset 0. Each channel owns a group of three 16-bit registers. The bus takes a byte address, a write strobe and 16-bit write data. Read data is registered: the value for the address presented in one cycle appears after the next clock edge. That value is the register contents as they stood just before that edge.

Top module: `ivt_timer`

## Requirements
- R1: After reset, the run register, both control words and both counters read 0x0000, both compare registers read 0xFFFF, and both interrupt lines are low.
- R2: The register at byte offset 0 holds one run bit per channel (bit n controls channel n) and reads back as written. Channels count independently of each other.
- R3: Channel n's control word is at byte offset 2+6n, its counter at 4+6n and its compare register at 6+6n. `rdata` shows the addressed register one clock edge after the address is presented.
- R4: In the control word, bit 7 is the match flag, bit 6 the interrupt enable and bits 1:0 the divide select. All other bits read 0. Writing 1 to bit 7 never sets the flag.
- R5: Divide select codes 0, 1, 2 and 3 give one count tick per 8, 32, 128 and 512 input clocks.
- R6: On a tick where the counter equals the compare value, the counter returns to 0 and the match flag is set. One period is therefore compare+1 ticks.
- R7: A control write with bit 7 = 0 clears the flag. A control write with bit 7 = 1 leaves it unchanged. A match in the same cycle as a clearing write keeps the flag set.
- R8: A channel's interrupt output is high exactly while its match flag and interrupt enable are both 1.
- R9: The counter and compare registers can be written at any time. A counter write in the same cycle as a tick wins, and that tick is dropped. A stopped channel's counter holds its value.
- R10: A channel's divider restarts from zero whenever the channel is stopped. The first tick after the run bit is set comes exactly one full divide period later.
- R11: Reads from unmapped or odd offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register accessed |
| we | input | 1 | Write strobe for `wdata` to `addr` |
| wdata | input | CW | Write data |
| rdata | output | CW | Registered read data for the previous cycle's address |
| irq | output | NUM_CH | Per-channel match interrupt |

## Verification
The bench times the first interrupt after a start to the exact cycle. An off-by-one in the wrap compare or a divider that does not restart would move the interrupt by a tick or a divide period. Short start/stop bursts check that a stopped divider forgets its partial count; a design that kept the partial count would produce a tick that should not exist. A counter write is placed on the same edge as a tick, so a design that let the tick win would be off by the preset value. Further checks cover flag writes with bit 7 set, which must not create or clear a flag, a flag latched while the interrupt enable is low, and writes to holes in the address map, which would otherwise corrupt a neighbouring register.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  // control word field positions (decoded by software drivers)
  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int SEL_W    = 2;
  // address map
  localparam int RUN_OFS    = 0;
  localparam int GRP_BASE   = 2;
  localparam int GRP_STRIDE = 6;
  localparam int REG_STEP   = 2;
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
  parameter int PRE_W = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] lim;

  // divide by 8 << (2*sel): terminal count is that minus one
  always_comb lim = PRE_W'((32'd8 << (2 * sel)) - 32'd1);

  assign tick = run && (pcnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run)  pcnt_q <= '0;
    else if (tick)    pcnt_q <= '0;
    else              pcnt_q <= pcnt_q + 1'b1;
  end

  // R10: a fresh start always begins from an empty divider
  a_r10_fresh_start: assert property (@(posedge clk) disable iff (rst)
    (run && !$past(run)) |-> (pcnt_q == '0));
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int CW    = 16,
  parameter int PRE_W = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          ctrl_we,
  input  logic          cnt_we,
  input  logic          cmp_we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] ctrl_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cmp_o,
  output logic          irq
);
  logic             flag_q, ie_q;
  logic [SEL_W-1:0] sel_q;
  logic [CW-1:0]    cnt_q, cmp_q;
  logic             tick, hit;

  ivt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk (clk),
    .rst (rst),
    .run (run),
    .sel (sel_q),
    .tick(tick)
  );

  // a software counter write swallows a coincident tick
  assign hit = tick && !cnt_we && (cnt_q == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      sel_q  <= '0;
      cnt_q  <= '0;
      cmp_q  <= '1;
    end else begin
      if (ctrl_we) begin
        ie_q   <= wdata[IE_BIT];
        sel_q  <= wdata[SEL_W-1:0];
        flag_q <= (flag_q & wdata[FLAG_BIT]) | hit;
      end else if (hit) begin
        flag_q <= 1'b1;
      end
      if (cnt_we)    cnt_q <= wdata;
      else if (tick) cnt_q <= hit ? '0 : cnt_q + 1'b1;
      if (cmp_we)    cmp_q <= wdata;
    end
  end

  always_comb begin
    ctrl_o              = '0;
    ctrl_o[FLAG_BIT]    = flag_q;
    ctrl_o[IE_BIT]      = ie_q;
    ctrl_o[SEL_W-1:0]   = sel_q;
  end
  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;
  assign irq   = flag_q & ie_q;

  // R1: values right after reset
  a_r1_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt_q == '0 && cmp_q == '1 && !flag_q && !irq));
  // R6: wrap to zero and latch the flag
  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_we && cnt_q == cmp_q) |=> (cnt_q == '0 && flag_q));
  // R6: otherwise a tick advances by one
  a_r6_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_we && cnt_q != cmp_q) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R7: a clearing write without a coincident match clears the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !wdata[FLAG_BIT] && !(tick && !cnt_we && cnt_q == cmp_q)) |=> !flag_q);
  // R9: software counter write wins
  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (cnt_q == $past(wdata)));
  // R9: a stopped counter holds
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_we) |=> $stable(cnt_q));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CW     = 16,
  parameter int ADDR_W = 4,
  parameter int PRE_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [CW-1:0]     wdata,
  output logic [CW-1:0]     rdata,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH-1:0] run_q;
  logic              run_sel;
  logic [NUM_CH-1:0] ctrl_sel, cnt_sel, cmp_sel;
  logic [CW-1:0]     ctrl_rd [NUM_CH];
  logic [CW-1:0]     cnt_rd  [NUM_CH];
  logic [CW-1:0]     cmp_rd  [NUM_CH];
  logic [CW-1:0]     rd_nxt, rd_q;

  assign run_sel = (addr == ADDR_W'(RUN_OFS));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int BASE = GRP_BASE + GRP_STRIDE * g;
    assign ctrl_sel[g] = (addr == ADDR_W'(BASE));
    assign cnt_sel[g]  = (addr == ADDR_W'(BASE + REG_STEP));
    assign cmp_sel[g]  = (addr == ADDR_W'(BASE + 2 * REG_STEP));

    ivt_channel #(.CW(CW), .PRE_W(PRE_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .run    (run_q[g]),
      .ctrl_we(we && ctrl_sel[g]),
      .cnt_we (we && cnt_sel[g]),
      .cmp_we (we && cmp_sel[g]),
      .wdata  (wdata),
      .ctrl_o (ctrl_rd[g]),
      .cnt_o  (cnt_rd[g]),
      .cmp_o  (cmp_rd[g]),
      .irq    (irq[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                 run_q <= '0;
    else if (we && run_sel)  run_q <= wdata[NUM_CH-1:0];
  end

  always_comb begin
    rd_nxt = '0;
    if (run_sel) rd_nxt = CW'(run_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (ctrl_sel[i]) rd_nxt = ctrl_rd[i];
      if (cnt_sel[i])  rd_nxt = cnt_rd[i];
      if (cmp_sel[i])  rd_nxt = cmp_rd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_nxt;
  end
  assign rdata = rd_q;

  // R2: the run register takes the written bits
  a_r2_run_write: assert property (@(posedge clk) disable iff (rst)
    (we && run_sel) |=> (run_q == $past(wdata[NUM_CH-1:0])));
  // R11: an unmapped read returns zero
  a_r11_hole_read: assert property (@(posedge clk) disable iff (rst)
    !(run_sel || (|ctrl_sel) || (|cnt_sel) || (|cmp_sel)) |=> (rdata == '0));
endmodule

// File: tb/ivt_timer_bench.sv
module ivt_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int last = 0;
  bit done = 0;

  logic        issue = 1'b0;
  logic        issued_d = 1'b0;
  logic [15:0] exp_q [$];
  string       tag_q [$];

  ivt_timer u_ivt_timer (
    .clk(clk), .rst(rst), .addr(addr), .we(we),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare read results against queued expectations
  always @(posedge clk) issued_d <= issue;
  always @(negedge clk) begin
    if (issued_d) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata=%h expected %h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    last = cyc;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string t);
    addr = a; we = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(t);
    issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", t, act, e);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int t0, t1, tw, s, e, w, acc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R3 map
    rd(0, 16'h0000, "R1 run reg");
    rd(2, 16'h0000, "R1 ctrl0");
    rd(4, 16'h0000, "R1 cnt0");
    rd(6, 16'hFFFF, "R1 cmp0 (R3 offset 6)");
    rd(8, 16'h0000, "R1 ctrl1");
    rd(10, 16'h0000, "R1 cnt1");
    rd(12, 16'hFFFF, "R1 cmp1 (R3 offset 12)");
    chk(irq[0], 1'b0, "R1 irq0");
    chk(irq[1], 1'b0, "R1 irq1");

    // R4 field readback, flag not set by writing 1
    wr(8, 16'hFFFF);
    rd(8, 16'h0043, "R4 ctrl1 fields");
    wr(8, 16'h0000);

    // R11 holes
    wr(14, 16'h1234);
    wr(3, 16'h5555);
    rd(14, 16'h0000, "R11 read offset 14");
    rd(3, 16'h0000, "R11 read odd offset");
    rd(2, 16'h0000, "R11 ctrl0 untouched");
    rd(4, 16'h0000, "R11 cnt0 untouched");

    // R6 period, R8 irq, R10 first tick
    wr(6, 16'd3);
    wr(2, 16'h0040);
    wr(0, 16'h0001); t0 = last;
    repeat (31) @(negedge clk);
    chk(irq[0], 1'b0, "R6 irq0 low before compare+1 ticks");
    @(negedge clk);
    chk(irq[0], 1'b1, "R6 R8 irq0 at 4 ticks of 8 clocks (R10)");
    wr(2, 16'h00C0);
    rd(2, 16'h00C0, "R7 writing 1 keeps flag");
    chk(irq[0], 1'b1, "R7 irq0 still high");
    wr(2, 16'h0040);
    chk(irq[0], 1'b0, "R7 flag cleared by 0");
    wr(0, 16'h0000); t1 = last;
    s = t1 - t0; e = (s / 8) % 4;
    rd(4, 16'(e), "R6 cnt0 after stop");
    repeat (20) @(negedge clk);
    rd(4, 16'(e), "R9 stopped counter holds");

    // R8 flag latched with enable low
    wr(12, 16'd1);
    wr(10, 16'd0);
    wr(8, 16'h0000);
    wr(0, 16'h0002);
    repeat (20) @(negedge clk);
    chk(irq[1], 1'b0, "R8 irq1 low with enable 0");
    wr(0, 16'h0000);
    rd(8, 16'h0080, "R6 flag1 set");
    wr(8, 16'h00C0);
    chk(irq[1], 1'b1, "R8 irq1 once enabled");
    wr(8, 16'h0000);
    chk(irq[1], 1'b0, "R7 irq1 cleared");

    // R5 divide ratios, R9 preset
    for (int sel = 1; sel < 4; sel++) begin
      int dv;
      dv = 8 << (2 * sel);
      wr(12, 16'hFFFF);
      wr(10, 16'd5);
      wr(8, 16'(sel));
      wr(0, 16'h0002); t0 = last;
      w = 2 * dv + 3;
      repeat (w) @(negedge clk);
      wr(0, 16'h0000); t1 = last;
      e = 5 + (t1 - t0) / dv;
      rd(10, 16'(e), $sformatf("R5 cnt1 with select %0d", sel));
    end

    // R2 both channels together
    wr(6, 16'd1);
    wr(4, 16'd0);
    wr(2, 16'h0000);
    wr(12, 16'hFFFF);
    wr(10, 16'd0);
    wr(8, 16'h0001);
    wr(0, 16'h0003); t0 = last;
    rd(0, 16'h0003, "R2 run reg readback");
    repeat (100) @(negedge clk);
    wr(0, 16'h0000); t1 = last;
    s = t1 - t0;
    rd(4, 16'((s / 8) % 2), "R2 cnt0 independent");
    rd(10, 16'(s / 32), "R2 cnt1 independent");
    rd(2, 16'h0080, "R2 flag0 set");
    wr(2, 16'h0000);

    // R9 counter write on a tick edge
    wr(6, 16'hFFFF);
    wr(4, 16'd0);
    wr(0, 16'h0001); t0 = last;
    repeat (7) @(negedge clk);
    wr(4, 16'd100); tw = last;
    repeat (20) @(negedge clk);
    wr(0, 16'h0000); t1 = last;
    e = 100 + (t1 - t0) / 8 - (tw - t0) / 8;
    rd(4, 16'(e), "R9 write wins over tick");

    // R10 divider cleared by stop
    wr(4, 16'd0);
    acc = 0;
    for (int k = 0; k < 3; k++) begin
      wr(0, 16'h0001); t0 = last;
      repeat (4) @(negedge clk);
      wr(0, 16'h0000); t1 = last;
      acc += (t1 - t0) / 8;
    end
    rd(4, 16'(acc), "R10 partial periods discarded");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule